// File: doc/BRIEF.md
# UART Command and Enable Sequencer

This block sits behind a write-only UART command register. Each write supplies a data word in which every set bit requests a one-shot action. The block turns those bits into enable levels for a transmitter and a receiver, single-cycle soft-reset pulses for each direction, and one status-clear pulse. A bit written as zero does nothing, so software can issue one command without touching the others.

A disable is graceful. It waits for the character in flight to finish, and on the transmit side also for one character already queued in the holding register, before it turns the enable off. The serial cores report their progress through busy inputs. A reset is not graceful: it drops the direction's enable in the same cycle and pulses that direction's reset, which aborts any character in flight. The enable outputs also serve as the readable on/off state of each direction.

All command effects, meaning enable changes and pulses, become visible in the clock cycle after the write strobe.

Top module: `uart_cmd_seq`

## Requirements
- R1: Each command bit acts only when the write strobe is high and the bit is 1. A write of all zeros, or cycles with the strobe low, change no output. Bit positions in the data word: receiver reset 2, transmitter reset 3, receiver enable 4, receiver disable 5, transmitter enable 6, transmitter disable 7, status clear 8.
- R2: An enable command turns its direction on only if the disable bit of the same direction is 0 in the same write. If both bits are set, the direction ends up off, or ends up draining if a character is in flight.
- R3: A transmitter disable with the transmitter busy or the holding register full keeps `tx_enable` high. It drops `tx_enable` in the cycle after a clock edge at which both inputs are low. If the transmitter is already idle, `tx_enable` drops in the cycle after the write.
- R4: A receiver disable with `rx_busy` high keeps `rx_enable` high until the cycle after a clock edge at which `rx_busy` is low. If the receiver is idle, `rx_enable` drops in the cycle after the write.
- R5: A transmitter reset drops `tx_enable` and raises `tx_soft_rst` in the cycle after the write, regardless of the busy inputs.
- R6: A receiver reset drops `rx_enable` and raises `rx_soft_rst` in the cycle after the write, regardless of `rx_busy`.
- R7: A status-clear command raises `status_clr` for one cycle. This pulse clears the parity, framing, match and overrun flags together.
- R8: A reset and a disable for the same direction in one write act as a reset. A reset also cancels any pending graceful disable of its direction.
- R9: An enable command that arrives while a graceful disable is pending cancels the pending disable, and the direction stays on after it goes idle.
- R10: Each soft-reset and status-clear pulse lasts exactly one cycle and is issued in the cycle after its write.
- R11: After a system reset both enables are low, no pulse is active and no disable is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 16 | Command word written |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_hold_full | input | 1 | Transmit holding register holds a queued character |
| rx_busy | input | 1 | Receiver is assembling a character |
| tx_enable | output | 1 | Transmitter enable level and readable state |
| rx_enable | output | 1 | Receiver enable level and readable state |
| tx_soft_rst | output | 1 | One-cycle transmitter reset pulse |
| rx_soft_rst | output | 1 | One-cycle receiver reset pulse |
| status_clr | output | 1 | One-cycle pulse clearing the error and match flags |

## Verification
The embedded assertions check the following on every cycle:
- a disable is only pending while its direction is enabled;
- an enable only falls through a reset pulse or on an idle edge;
- an enable only rises after an enable command without a same-write disable;
- every pulse traces back to a command bit in the previous cycle.

Only the bench scenarios show the ordered behaviour:
- draining through a busy shifter and then through a queued holding character;
- an enable cancelling a pending disable;
- a combined reset-and-disable write cancelling a drain so it never resumes;
- zero writes leaving all state untouched.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int CMD_W      = 16;
  localparam int B_RX_RST   = 2;
  localparam int B_TX_RST   = 3;
  localparam int B_RX_ON    = 4;
  localparam int B_RX_OFF   = 5;
  localparam int B_TX_ON    = 6;
  localparam int B_TX_OFF   = 7;
  localparam int B_STA_CLR  = 8;
  localparam int N_DIR      = 2;
  localparam int DIR_TX     = 0;
  localparam int DIR_RX     = 1;

  typedef struct packed {
    logic [N_DIR-1:0] rst;
    logic [N_DIR-1:0] on;
    logic [N_DIR-1:0] off;
    logic             sta_clr;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic             wr,
  input  logic [CMD_W-1:0] data,
  output cmd_t             cmd
);
  always_comb begin
    cmd.rst[DIR_TX] = wr & data[B_TX_RST];
    cmd.rst[DIR_RX] = wr & data[B_RX_RST];
    cmd.on[DIR_TX]  = wr & data[B_TX_ON];
    cmd.on[DIR_RX]  = wr & data[B_RX_ON];
    cmd.off[DIR_TX] = wr & data[B_TX_OFF];
    cmd.off[DIR_RX] = wr & data[B_RX_OFF];
    cmd.sta_clr     = wr & data[B_STA_CLR];
  end
endmodule

// File: rtl/uart_dir_ctrl.sv
module uart_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rst,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic busy,
  output logic en,
  output logic rst_pulse
);
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic pls_q, pls_d;
  logic upd;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    pls_d  = cmd_rst;
    if (cmd_rst) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end else if (cmd_off) begin
      if (en_q && busy) begin
        pend_d = 1'b1;
      end else begin
        en_d   = 1'b0;
        pend_d = 1'b0;
      end
    end else if (cmd_on) begin
      en_d   = 1'b1;
      pend_d = 1'b0;
    end else if (pend_q && !busy) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end
  end

  assign upd = (en_d != en_q) || (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pls_q <= 1'b0;
    else        pls_q <= pls_d;
  end

  assign en        = en_q;
  assign rst_pulse = pls_q;

  // R3 R4 R9
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q);

  // R3 R4 R5 R6
  en_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (pls_q || !$past(busy)));

  // R2
  en_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(cmd_on && !cmd_off && !cmd_rst));

  // R10
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q |-> ($past(cmd_rst) && !en_q));
endmodule

// File: rtl/uart_cmd_seq.sv
module uart_cmd_seq
  import uart_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             tx_busy,
  input  logic             tx_hold_full,
  input  logic             rx_busy,
  output logic             tx_enable,
  output logic             rx_enable,
  output logic             tx_soft_rst,
  output logic             rx_soft_rst,
  output logic             status_clr
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  cmd_t             cmd;
  logic [N_DIR-1:0] dir_busy;
  logic [N_DIR-1:0] dir_en;
  logic [N_DIR-1:0] dir_pls;
  logic             sta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_cmd_decode u_dec (
    .wr   (cmd_wr),
    .data (cmd_data),
    .cmd  (cmd)
  );

  assign dir_busy[DIR_TX] = tx_busy | tx_hold_full;
  assign dir_busy[DIR_RX] = rx_busy;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    uart_dir_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cmd_rst   (cmd.rst[d]),
      .cmd_on    (cmd.on[d]),
      .cmd_off   (cmd.off[d]),
      .busy      (dir_busy[d]),
      .en        (dir_en[d]),
      .rst_pulse (dir_pls[d])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sta_q <= 1'b0;
    else            sta_q <= cmd.sta_clr;
  end

  assign tx_enable   = dir_en[DIR_TX];
  assign rx_enable   = dir_en[DIR_RX];
  assign tx_soft_rst = dir_pls[DIR_TX];
  assign rx_soft_rst = dir_pls[DIR_RX];
  assign status_clr  = sta_q;

  // R7
  sta_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sta_q |-> $past(cmd_wr && cmd_data[B_STA_CLR]));

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(cmd_wr) |-> !(tx_soft_rst || rx_soft_rst || status_clr));
endmodule

// File: tb/tb_uart_cmd_seq.sv
module tb_uart_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        tx_busy = 1'b0, tx_hold_full = 1'b0, rx_busy = 1'b0;
  logic        tx_enable, rx_enable, tx_soft_rst, rx_soft_rst, status_clr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  uart_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .tx_busy(tx_busy), .tx_hold_full(tx_hold_full), .rx_busy(rx_busy),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_soft_rst(tx_soft_rst),
    .rx_soft_rst(rx_soft_rst), .status_clr(status_clr)
  );

  // {wr, data, {txb,thr,rxb}, {tx_en,rx_en,tx_rst,rx_rst,sta}}
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h0050, 3'b000, 5'b11000},
    {1'b1, 16'h0080, 3'b100, 5'b11000},
    {1'b0, 16'h0000, 3'b010, 5'b11000},
    {1'b0, 16'h0000, 3'b000, 5'b01000},
    {1'b1, 16'h0020, 3'b001, 5'b01000},
    {1'b0, 16'h0000, 3'b000, 5'b00000},
    {1'b1, 16'h00F0, 3'b000, 5'b00000},
    {1'b1, 16'h0050, 3'b000, 5'b11000},
    {1'b1, 16'h0100, 3'b000, 5'b11001},
    {1'b1, 16'h0000, 3'b000, 5'b11000},
    {1'b1, 16'h0080, 3'b100, 5'b11000},
    {1'b1, 16'h0040, 3'b100, 5'b11000},
    {1'b0, 16'h0000, 3'b000, 5'b11000},
    {1'b1, 16'h0008, 3'b100, 5'b01100},
    {1'b1, 16'h0004, 3'b001, 5'b00010},
    {1'b1, 16'h0050, 3'b000, 5'b11000},
    {1'b1, 16'h00A0, 3'b101, 5'b11000},
    {1'b1, 16'h000C, 3'b101, 5'b00110},
    {1'b0, 16'h0000, 3'b000, 5'b00000},
    {1'b1, 16'h0050, 3'b000, 5'b11000},
    {1'b1, 16'h0088, 3'b100, 5'b01100},
    {1'b1, 16'h0060, 3'b000, 5'b10000}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 7, 15, 19: return "R2";
      1, 2, 3:      return "R3";
      4, 5:         return "R4";
      6, 21:        return "R2";
      8:            return "R7";
      9:            return "R1";
      10, 11, 12:   return "R9";
      13:           return "R5";
      14:           return "R6";
      16, 17, 18:   return "R8";
      20:           return "R8";
      default:      return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {tx_enable, rx_enable, tx_soft_rst, rx_soft_rst, status_clr};
  endfunction

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state while held
    check("R11", outs(), 5'b00000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", outs(), 5'b00000);
    for (int i = 0; i < NV; i++) begin
      cmd_wr   = VEC[i][24];
      cmd_data = VEC[i][23:8];
      {tx_busy, tx_hold_full, rx_busy} = VEC[i][7:5];
      @(negedge clk);
      check(vec_req(i), outs(), VEC[i][4:0]);
    end
    cmd_wr = 1'b0; cmd_data = '0;
    {tx_busy, tx_hold_full, rx_busy} = 3'b000;
    // R10: pulse gone one cycle after a reset/clear write
    cmd_wr = 1'b1; cmd_data = 16'h010C;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
    check("R10", outs(), 5'b00111);
    @(negedge clk);
    check("R10", outs(), 5'b00000);
    // R1: strobe low with command bits present has no effect
    cmd_data = 16'h01FC;
    repeat (2) @(negedge clk);
    check("R1", outs(), 5'b00000);
    cmd_data = '0;
    // R11: system reset mid-operation clears enables
    cmd_wr = 1'b1; cmd_data = 16'h0050;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
    check("R2", outs(), 5'b11000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", outs(), 5'b00000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", outs(), 5'b00000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule